// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Flag Byte

This block is the purely combinational arithmetic and logic stage of a small accumulator machine. Each cycle it takes an operation code, the accumulator, an 8-bit operand and the current flag byte. It returns an 8-bit result and the next flag byte. A second datapath handles 16-bit register-pair arithmetic on two pair inputs and returns a 16-bit result. Instruction decode, the register file and memory sit outside the block. The caller writes back whichever result the operation produces.

Every operation class follows its own rule for each flag bit. Logic operations report parity where arithmetic reports signed overflow. Some operations keep carry and others clear it. Pair increment and decrement leave the whole flag byte alone. The subtract flag steers the decimal adjust, which turns a binary sum or difference of two packed-BCD bytes into a valid BCD result.

Top module: `alu8_flags`

## Requirements
- R1: The flag byte is laid out as bit 7 sign, bit 6 zero, bit 4 half-carry, bit 2 parity/overflow, bit 1 subtract and bit 0 carry. Bits 5 and 3 are always copied from flags_i to flags_o.
- R2: Opcode 0 (add) and opcode 1 (add with carry) produce acc+opnd (+carry). Sign is result bit 7 and zero is set when the result is 0. Half-carry is the carry into bit 4, overflow is signed overflow, subtract is 0 and carry is the carry out of bit 7.
- R3: Opcode 2 (subtract) and opcode 3 (subtract with carry) produce acc-opnd (-carry), with borrows in the half-carry and carry bits, signed overflow in bit 2 and subtract set to 1. Subtract with carry of a value from itself gives 0x00 when carry is 0, and 0xFF with carry set when carry is 1.
- R4: Opcode 4 (compare) sets the flags exactly as subtract would, and res_o equals acc_i.
- R5: Opcodes 5, 6 and 7 (AND, OR, XOR) set bit 2 to 1 for an even count of ones in the result, and clear subtract and carry. Half-carry is 1 for AND and 0 for OR and XOR.
- R6: Opcode 8 (negate) yields 0-acc and updates every flag. Carry is set unless acc is 0, and overflow is set only for 0x80.
- R7: Opcode 11 (increment) and opcode 12 (decrement) on the accumulator update sign, zero, half-carry, overflow and subtract (0 for increment, 1 for decrement). Carry is kept.
- R8: Opcode 9 (complement) inverts every accumulator bit and leaves flags unchanged. Opcode 10 (complement carry) inverts only flag bit 0 and passes the accumulator through.
- R9: Opcode 13 (decimal adjust) adds 0x06 when the low nibble is above 9 or half-carry is set, and adds 0x60 when acc is above 0x99 or carry is set. It subtracts these corrections instead when subtract is 1. The new carry is set when the high correction was applied. Parity goes to bit 2 and subtract is kept.
- R10: Opcode 16 (pair add) produces pair_a+pair_b. Half-carry is the carry into bit 12, carry is the carry out of bit 15 and subtract is 0. Sign, zero and overflow are kept.
- R11: Opcode 17 (pair add with carry) and opcode 18 (pair subtract with carry) update every flag on the 16-bit result. Sign is bit 15, zero means all 16 bits are clear, half-carry comes from bit 11 and carry from bit 15.
- R12: Opcode 19 (pair increment) and opcode 20 (pair decrement) wrap pair_a modulo 65536 and leave flags_o equal to flags_i.
- R13: On 8-bit operations pair_res_o equals pair_a_i. On pair operations res_o equals acc_i. Any other opcode passes acc_i, pair_a_i and flags_i through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second 8-bit operand |
| pair_a_i | input | 16 | First register-pair operand |
| pair_b_i | input | 16 | Second register-pair operand |
| flags_i | input | 8 | Incoming flag byte |
| res_o | output | 8 | 8-bit result |
| pair_res_o | output | 16 | 16-bit result |
| flags_o | output | 8 | Outgoing flag byte |

## Verification
The sharpest overlap is bit 2 serving as both signed overflow and parity. It is provoked by pairing operands that overflow with an odd-parity result, such as 0x7F plus one. It is also provoked by logic results whose parity differs from any overflow reading. The bench judges which meaning won from the exact byte. A second overlap arises when one operation raises a carry out and a half-carry at once, as in decimal adjust of 0x9A and pair add of 0xFFFF plus one. Both bits are compared against hand-computed flag bytes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int PW  = 2 * DW;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CP   = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_NEG  = 5'd8,
    OP_CPL  = 5'd9,
    OP_CCF  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_DAA  = 5'd13,
    OP_PADD = 5'd16,
    OP_PADC = 5'd17,
    OP_PSBC = 5'd18,
    OP_PINC = 5'd19,
    OP_PDEC = 5'd20
  } op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic u5;
    logic h;
    logic u3;
    logic pv;
    logic n;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         half_o,
  output logic         ovf_o
);
  localparam int HB = W - 4;
  localparam int HW = HB + 1;
  localparam int FW = W + 1;

  logic [W-1:0]  b_eff;
  logic          cin_eff;
  logic [FW-1:0] full;
  logic [HW-1:0] part;

  // subtraction as a + ~b + ~borrow; carries inverted back to borrows
  assign b_eff   = sub_i ? ~b_i : b_i;
  assign cin_eff = cin_i ^ sub_i;
  assign full    = {1'b0, a_i} + {1'b0, b_eff} + FW'(cin_eff);
  assign part    = {1'b0, a_i[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + HW'(cin_eff);

  assign sum_o   = full[W-1:0];
  assign carry_o = full[W] ^ sub_i;
  assign half_o  = part[HB] ^ sub_i;
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);

  always_comb begin
    if (!sub_i && !cin_i && b_i == '0)
      AST_ADD_ZERO_IDENT: assert (sum_o == a_i && !carry_o && !half_o && !ovf_o); // R2
    if (sub_i && !cin_i && b_i == a_i)
      AST_SUB_SELF_ZERO: assert (sum_o == '0 && !carry_o && !ovf_o); // R3
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o,
  output logic         par_even_o
);
  always_comb begin
    case (sel_i)
      2'd1:    res_o = a_i | b_i;
      2'd2:    res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;
    endcase
  end

  assign par_even_o = ~^res_o;

  always_comb begin
    if (res_o == '0)
      AST_ZERO_EVEN_PARITY: assert (par_even_o); // R5
    if (sel_i == 2'd0)
      AST_AND_SUBSET: assert ((res_o & ~a_i) == '0); // R5
  end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa (
  input  logic [7:0] acc_i,
  input  logic       n_i,
  input  logic       h_i,
  input  logic       c_i,
  output logic [7:0] res_o,
  output logic       h_o,
  output logic       c_o
);
  logic       lo_fix;
  logic       hi_fix;
  logic [7:0] corr;

  assign lo_fix = h_i || (acc_i[3:0] > 4'd9);
  assign hi_fix = c_i || (acc_i > 8'h99);
  assign corr   = {(hi_fix ? 4'h6 : 4'h0), (lo_fix ? 4'h6 : 4'h0)};
  assign res_o  = n_i ? (acc_i - corr) : (acc_i + corr);
  assign c_o    = hi_fix;
  assign h_o    = n_i ? (h_i && (acc_i[3:0] < 4'd6)) : (acc_i[3:0] > 4'd9);

  always_comb begin
    if (!c_i && !h_i && acc_i[3:0] <= 4'd9 && acc_i[7:4] <= 4'd9)
      AST_DAA_VALID_BCD_KEPT: assert (res_o == acc_i && !c_o); // R9
    if (c_i)
      AST_DAA_CARRY_STICKS: assert (c_o); // R9
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opnd_i,
  input  logic [PW-1:0]  pair_a_i,
  input  logic [PW-1:0]  pair_b_i,
  input  logic [DW-1:0]  flags_i,
  output logic [DW-1:0]  res_o,
  output logic [PW-1:0]  pair_res_o,
  output logic [DW-1:0]  flags_o
);
  op_e    op;
  flags_t fi;
  flags_t fo;

  assign op = op_e'(op_i);
  assign fi = flags_t'(flags_i);

  // 8-bit adder operand steering
  logic [DW-1:0] a8, b8, sum8;
  logic          c8, s8, co8, h8, v8;

  always_comb begin
    a8 = acc_i;
    b8 = opnd_i;
    c8 = 1'b0;
    s8 = 1'b0;
    case (op)
      OP_ADC:         c8 = fi.c;
      OP_SUB, OP_CP:  s8 = 1'b1;
      OP_SBC: begin
        s8 = 1'b1;
        c8 = fi.c;
      end
      OP_NEG: begin
        a8 = '0;
        b8 = acc_i;
        s8 = 1'b1;
      end
      OP_INC:         b8 = DW'(1);
      OP_DEC: begin
        b8 = DW'(1);
        s8 = 1'b1;
      end
      default: ;
    endcase
  end

  alu_addsub #(.W(DW)) u_add8 (
    .a_i(a8), .b_i(b8), .cin_i(c8), .sub_i(s8),
    .sum_o(sum8), .carry_o(co8), .half_o(h8), .ovf_o(v8)
  );

  // 16-bit pair adder operand steering
  logic [PW-1:0] b16, sum16;
  logic          c16, s16, co16, h16, v16;

  always_comb begin
    b16 = pair_b_i;
    c16 = 1'b0;
    s16 = 1'b0;
    case (op)
      OP_PADC: c16 = fi.c;
      OP_PSBC: begin
        c16 = fi.c;
        s16 = 1'b1;
      end
      OP_PINC: b16 = PW'(1);
      OP_PDEC: begin
        b16 = PW'(1);
        s16 = 1'b1;
      end
      default: ;
    endcase
  end

  alu_addsub #(.W(PW)) u_add16 (
    .a_i(pair_a_i), .b_i(b16), .cin_i(c16), .sub_i(s16),
    .sum_o(sum16), .carry_o(co16), .half_o(h16), .ovf_o(v16)
  );

  logic [1:0]    lsel;
  logic [DW-1:0] lres;
  logic          lpar;

  assign lsel = (op == OP_OR) ? 2'd1 : (op == OP_XOR) ? 2'd2 : 2'd0;

  alu8_logic #(.W(DW)) u_logic (
    .a_i(acc_i), .b_i(opnd_i), .sel_i(lsel), .res_o(lres), .par_even_o(lpar)
  );

  logic [DW-1:0] dres;
  logic          dh, dc;

  alu8_daa u_daa (
    .acc_i(acc_i), .n_i(fi.n), .h_i(fi.h), .c_i(fi.c),
    .res_o(dres), .h_o(dh), .c_o(dc)
  );

  // result and flag merge; unused bits 5 and 3 never written
  always_comb begin
    fo         = fi;
    res_o      = acc_i;
    pair_res_o = pair_a_i;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_NEG: begin
        res_o = (op == OP_CP) ? acc_i : sum8;
        fo.s  = sum8[DW-1];
        fo.z  = (sum8 == '0);
        fo.h  = h8;
        fo.pv = v8;
        fo.n  = s8;
        fo.c  = co8;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_o = lres;
        fo.s  = lres[DW-1];
        fo.z  = (lres == '0);
        fo.h  = (op == OP_AND);
        fo.pv = lpar;
        fo.n  = 1'b0;
        fo.c  = 1'b0;
      end
      OP_INC, OP_DEC: begin
        res_o = sum8;
        fo.s  = sum8[DW-1];
        fo.z  = (sum8 == '0);
        fo.h  = h8;
        fo.pv = v8;
        fo.n  = s8;
      end
      OP_CPL: res_o = ~acc_i;
      OP_CCF: fo.c = ~fi.c;
      OP_DAA: begin
        res_o = dres;
        fo.s  = dres[DW-1];
        fo.z  = (dres == '0);
        fo.h  = dh;
        fo.pv = ~^dres;
        fo.c  = dc;
      end
      OP_PADD: begin
        pair_res_o = sum16;
        fo.h       = h16;
        fo.n       = 1'b0;
        fo.c       = co16;
      end
      OP_PADC, OP_PSBC: begin
        pair_res_o = sum16;
        fo.s       = sum16[PW-1];
        fo.z       = (sum16 == '0);
        fo.h       = h16;
        fo.pv      = v16;
        fo.n       = s16;
        fo.c       = co16;
      end
      OP_PINC, OP_PDEC: pair_res_o = sum16;
      default: ;
    endcase
  end

  assign flags_o = fo;

  always_comb begin
    AST_UNUSED_BITS_PASS: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3]); // R1
    if (op == OP_CP)
      AST_CP_KEEPS_ACC: assert (res_o == acc_i); // R4
    if (op == OP_AND || op == OP_OR || op == OP_XOR)
      AST_LOGIC_CLEARS_NC: assert (!flags_o[0] && !flags_o[1]); // R5
    if (op == OP_INC || op == OP_DEC)
      AST_STEP_KEEPS_CARRY: assert (flags_o[0] == flags_i[0]); // R7
    if (op == OP_CPL)
      AST_CPL_FLAGS_HELD: assert (flags_o == flags_i); // R8
    if (op == OP_PINC || op == OP_PDEC)
      AST_PAIR_STEP_NO_FLAGS: assert (flags_o == flags_i); // R12
    if (op_i < 5'd16)
      AST_PAIR_IDLE_ON_8BIT: assert (pair_res_o == pair_a_i); // R13
  end
endmodule

// File: tb/tb_alu8_flags.sv
`timescale 1ns/1ps
module tb_alu8_flags;
  logic       clk = 1'b0;
  logic [4:0] op_i;
  logic [7:0] acc_i, opnd_i, flags_i;
  logic [15:0] pair_a_i, pair_b_i;
  logic [7:0] res_o, flags_o;
  logic [15:0] pair_res_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  alu8_flags dut (
    .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .pair_a_i(pair_a_i), .pair_b_i(pair_b_i), .flags_i(flags_i),
    .res_o(res_o), .pair_res_o(pair_res_o), .flags_o(flags_o)
  );

  task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] pa, input logic [15:0] pb, input logic [7:0] f);
    @(posedge clk);
    op_i = op; acc_i = a; opnd_i = b; pair_a_i = pa; pair_b_i = pb; flags_i = f;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op8(input string tag, input logic [4:0] op, input logic [7:0] a,
                     input logic [7:0] b, input logic [7:0] f,
                     input logic [7:0] er, input logic [7:0] ef);
    drive(op, a, b, 16'hBEEF, 16'h1111, f);
    chk({tag, " res"}, {8'h0, res_o}, {8'h0, er});
    chk({tag, " flags"}, {8'h0, flags_o}, {8'h0, ef});
  endtask

  task automatic op16(input string tag, input logic [4:0] op, input logic [15:0] pa,
                      input logic [15:0] pb, input logic [7:0] f,
                      input logic [15:0] er, input logic [7:0] ef);
    drive(op, 8'h5A, 8'h00, pa, pb, f);
    chk({tag, " pair"}, pair_res_o, er);
    chk({tag, " flags"}, {8'h0, flags_o}, {8'h0, ef});
    chk({tag, " acc pass R13"}, {8'h0, res_o}, 16'h005A);
  endtask

  task automatic t_idle;
    drive(5'd31, 8'hC3, 8'h12, 16'h4321, 16'h0001, 8'hA5);
    chk("R13 idle res", {8'h0, res_o}, 16'h00C3);
    chk("R13 idle pair", pair_res_o, 16'h4321);
    chk("R13 idle flags", {8'h0, flags_o}, 16'h00A5);
  endtask

  task automatic t_add;
    op8("R2 add bcd pair", 5'd0, 8'h16, 8'h26, 8'h00, 8'h3C, 8'h00);
    op8("R2 add overflow", 5'd0, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h94);
    op8("R2 adc wrap", 5'd1, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h51);
    op8("R1 unused kept", 5'd0, 8'h01, 8'h01, 8'h28, 8'h02, 8'h28);
    drive(5'd0, 8'h01, 8'h02, 16'hBEEF, 16'h0000, 8'h00);
    chk("R13 pair idle on add", pair_res_o, 16'hBEEF);
  endtask

  task automatic t_sub;
    op8("R3 sub half borrow", 5'd2, 8'h42, 8'h06, 8'h00, 8'h3C, 8'h12);
    op8("R3 sub overflow", 5'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h16);
    op8("R3 sbc self c0", 5'd3, 8'h55, 8'h55, 8'h00, 8'h00, 8'h42);
    op8("R3 sbc self c1", 5'd3, 8'h55, 8'h55, 8'h01, 8'hFF, 8'h93);
  endtask

  task automatic t_cmp;
    op8("R4 cp less", 5'd4, 8'h10, 8'h20, 8'h00, 8'h10, 8'h83);
    op8("R4 cp equal", 5'd4, 8'h33, 8'h33, 8'h00, 8'h33, 8'h42);
  endtask

  task automatic t_logic;
    op8("R5 and", 5'd5, 8'hF0, 8'h3C, 8'h01, 8'h30, 8'h14);
    op8("R5 or", 5'd6, 8'h01, 8'h02, 8'h03, 8'h03, 8'h04);
    op8("R5 xor odd", 5'd7, 8'h0F, 8'h0E, 8'h01, 8'h01, 8'h00);
    op8("R5 xor zero", 5'd7, 8'hAA, 8'hAA, 8'h00, 8'h00, 8'h44);
  endtask

  task automatic t_neg;
    op8("R6 neg one", 5'd8, 8'h01, 8'h00, 8'h00, 8'hFF, 8'h93);
    op8("R6 neg min", 5'd8, 8'h80, 8'h00, 8'h00, 8'h80, 8'h87);
    op8("R6 neg zero", 5'd8, 8'h00, 8'h00, 8'h01, 8'h00, 8'h42);
  endtask

  task automatic t_step;
    op8("R7 inc 7f", 5'd11, 8'h7F, 8'h00, 8'h01, 8'h80, 8'h95);
    op8("R7 inc ff", 5'd11, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h50);
    op8("R7 dec 80", 5'd12, 8'h80, 8'h00, 8'h01, 8'h7F, 8'h17);
    op8("R7 dec 01", 5'd12, 8'h01, 8'h00, 8'h00, 8'h00, 8'h42);
  endtask

  task automatic t_cpl_ccf;
    op8("R8 cpl", 5'd9, 8'hD5, 8'h00, 8'hA5, 8'h2A, 8'hA5);
    op8("R8 ccf set", 5'd10, 8'h11, 8'h00, 8'h01, 8'h11, 8'h00);
    op8("R8 ccf clr", 5'd10, 8'h11, 8'h00, 8'hC2, 8'h11, 8'hC3);
  endtask

  task automatic t_daa;
    op8("R9 daa after add", 5'd13, 8'h3C, 8'h00, 8'h00, 8'h42, 8'h14);
    op8("R9 daa after sub", 5'd13, 8'h3C, 8'h00, 8'h12, 8'h36, 8'h06);
    op8("R9 daa high wrap", 5'd13, 8'h9A, 8'h00, 8'h00, 8'h00, 8'h55);
  endtask

  task automatic t_pair;
    op16("R10 padd half", 5'd16, 16'h0FFF, 16'h0001, 8'hC6, 16'h1000, 8'hD4);
    op16("R10 padd wrap", 5'd16, 16'hFFFF, 16'h0001, 8'h00, 16'h0000, 8'h11);
    op16("R11 padc ovf", 5'd17, 16'h7FFF, 16'h0000, 8'h01, 16'h8000, 8'h94);
    op16("R11 psbc zero", 5'd18, 16'h1234, 16'h1234, 8'h00, 16'h0000, 8'h42);
    op16("R11 psbc borrow", 5'd18, 16'h0000, 16'h0001, 8'h00, 16'hFFFF, 8'h93);
    op16("R12 pinc wrap", 5'd19, 16'hFFFF, 16'h0000, 8'h81, 16'h0000, 8'h81);
    op16("R12 pdec wrap", 5'd20, 16'h0000, 16'h0000, 8'h40, 16'hFFFF, 8'h40);
  endtask

  initial begin
    op_i = 5'd31; acc_i = '0; opnd_i = '0; flags_i = '0; pair_a_i = '0; pair_b_i = '0;
    t_idle();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_neg();
    t_step();
    t_cpl_ccf();
    t_daa();
    t_pair();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule